// File: doc/BRIEF.md
# Data Memory Register File with Indirect Pointer Access

This block is the 64-byte data space of a small 8-bit core. A 6-bit address selects one byte. Reads are combinational, and writes take effect on the rising clock edge. The low addresses hold a few special registers:

- an indirect port that has no storage of its own,
- a 7-bit pointer register,
- the accumulator,
- the status register.

The upper half, 20H to 3FH, is 32 bytes of general-purpose RAM. Every other location below 20H reads as zero and ignores writes. Those locations stand in for peripherals that live elsewhere.

A read or write at address 00H is redirected to the location named by the pointer. Bit 6 of the pointer is ignored when forming that address. If the redirection lands on 00H again, the read yields zero and the write is dropped.

The status register has three kinds of content:

- Four arithmetic flags. The ALU loads them through a dedicated strobe, and software can also write them.
- A power-down bit, driven by halt and clear-watchdog strobes from the core.
- A time-out bit, driven by those strobes and by a watchdog expiry strobe.

Top module: `regfile_dmem`

## Requirements
- R1: An access to address 00H acts on the location whose address is the pointer value. A write there updates that location, and a read there returns its content.
- R2: When the redirected address is 00H, an indirect read returns 00H and an indirect write changes no location.
- R3: The pointer at 01H stores the low 7 bits of written data. Reading 01H returns bit 7 as 1 and bits 6:0 as the stored value.
- R4: Pointer bit 6 is ignored for redirection. For example, pointer 65H reaches 25H and pointer 40H counts as a self-reference.
- R5: The accumulator at 05H and the RAM at 20H–3FH return the last value written. The accumulator value is also driven on `acc_value`.
- R6: Every other address from 02H to 1FH reads 00H. A write to such an address changes no readable location.
- R7: The status register at 0AH reads as follows:
  - bit 0 is C, bit 1 is AC, bit 2 is Z, bit 3 is OV;
  - bit 4 is the power-down bit and bit 5 is the time-out bit;
  - bits 7:6 read 0.
  A software write to 0AH loads bits 3:0 only.
- R8: A clear-watchdog strobe clears the power-down bit, and a halt strobe sets it. When both arrive together, the clear wins.
- R9: A clear-watchdog or halt strobe clears the time-out bit, and a watchdog expiry strobe sets it. When a clear or halt arrives together with an expiry, the clear wins.
- R10: The ALU flag strobe loads C, AC, Z and OV. It wins over a software write to 0AH in the same cycle.
- R11: Synchronous active-low reset clears the pointer, the accumulator and every status bit. After reset, 01H reads 80H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Combinational read data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data |
| alu_flag_we | input | 1 | ALU flag update strobe |
| alu_c | input | 1 | New carry flag |
| alu_ac | input | 1 | New auxiliary carry flag |
| alu_z | input | 1 | New zero flag |
| alu_ov | input | 1 | New overflow flag |
| core_halt | input | 1 | Halt event strobe |
| core_wdt_clear | input | 1 | Clear-watchdog event strobe |
| wdt_timeout | input | 1 | Watchdog expiry strobe |
| acc_value | output | 8 | Current accumulator content |

## Verification
Direct accesses to the accumulator, RAM and pointer establish the plain storage path. Indirect accesses with pointer values in range, with bit 6 set, and equal to 00H or 40H separate correct redirection from self-reference handling and from bit-6 wrapping. A sweep of the unused addresses, with writes aimed at them, shows that they neither store nor disturb real registers. Paired event strobes and a flag strobe that coincides with a software write to 0AH exercise each arbitration order.

// File: rtl/dm_pkg.sv
// Package: shared types for the data memory register file.
// Assumes: the status flag field maps to status bits 3:0 in the order C, AC, Z, OV.
package dm_pkg;

    // Kind of storage a resolved address lands on
    typedef enum logic [2:0] {
        LOC_VOID,
        LOC_PTR,
        LOC_ACC,
        LOC_STAT,
        LOC_RAM
    } loc_kind_e;

    // Arithmetic flags; packed so that bit 0 is C and bit 3 is OV
    typedef struct packed {
        logic ov;
        logic z;
        logic ac;
        logic c;
    } alu_flags_t;

    localparam int FLAG_W = 4;

endpackage

// File: rtl/dm_addr_route.sv
// Module: dm_addr_route
// Resolves a raw address into the address actually touched, and classifies it.
// Address zero is redirected through the pointer (low ADDR_W bits only).
// A result of zero is the self-reference case and is classified as void.
// Assumes: GP_BASE + GP_DEPTH <= 2**ADDR_W.
module dm_addr_route
    import dm_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int PTR_ADDR  = 1,
    parameter int ACC_ADDR  = 5,
    parameter int STAT_ADDR = 10,
    parameter int GP_BASE   = 32,
    parameter int GP_DEPTH  = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] ptr_low_i,
    output logic [ADDR_W-1:0] eff_addr_o,
    output loc_kind_e         kind_o
);

    logic [ADDR_W-1:0] gp_off;

    // Pick the direct address or the pointer target
    always_comb begin
        eff_addr_o = (addr_i == '0) ? ptr_low_i : addr_i;
    end

    // Offset into the RAM window; wraps high when below the base
    always_comb begin
        gp_off = eff_addr_o - ADDR_W'(GP_BASE);
    end

    // Classify the resolved address
    always_comb begin
        if (eff_addr_o == '0)
            kind_o = LOC_VOID;
        else if (eff_addr_o == ADDR_W'(PTR_ADDR))
            kind_o = LOC_PTR;
        else if (eff_addr_o == ADDR_W'(ACC_ADDR))
            kind_o = LOC_ACC;
        else if (eff_addr_o == ADDR_W'(STAT_ADDR))
            kind_o = LOC_STAT;
        else if (int'(gp_off) < GP_DEPTH)
            kind_o = LOC_RAM;
        else
            kind_o = LOC_VOID;
    end

endmodule

// File: rtl/dm_gp_ram.sv
// Module: dm_gp_ram
// General-purpose byte RAM with one synchronous write port and one asynchronous read port.
// Assumes: the caller passes a window-relative index; contents are not reset.
module dm_gp_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a byte on the clock edge when enabled
    always_ff @(posedge clk) begin
        if (we_i)
            mem[wr_idx_i] <= wr_data_i;
    end

    // Combinational read
    always_comb begin
        rd_data_o = mem[rd_idx_i];
    end

endmodule

// File: rtl/dm_status_reg.sv
// Module: dm_status_reg
// Status register: four ALU flags, a power-down bit and a time-out bit.
// The ALU strobe wins over a software flag write.
// A clear-watchdog strobe wins over halt, and both win over a watchdog expiry.
// Assumes: synchronous active-low reset models power-up.
module dm_status_reg
    import dm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we_i,
    input  alu_flags_t        sw_flags_i,
    input  logic              alu_we_i,
    input  alu_flags_t        alu_flags_i,
    input  logic              halt_i,
    input  logic              wdt_clr_i,
    input  logic              wdt_tmo_i,
    output logic [DATA_W-1:0] status_o
);

    alu_flags_t flags_q;
    logic       pdf_q;
    logic       to_q;

    // Arithmetic flags: ALU strobe first, then software write
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else if (alu_we_i)
            flags_q <= alu_flags_i;
        else if (sw_we_i)
            flags_q <= sw_flags_i;
    end

    // Power-down bit: clear-watchdog clears, halt sets
    always_ff @(posedge clk) begin
        if (!rst_n)
            pdf_q <= 1'b0;
        else if (wdt_clr_i)
            pdf_q <= 1'b0;
        else if (halt_i)
            pdf_q <= 1'b1;
    end

    // Time-out bit: clear-watchdog or halt clears, expiry sets
    always_ff @(posedge clk) begin
        if (!rst_n)
            to_q <= 1'b0;
        else if (wdt_clr_i || halt_i)
            to_q <= 1'b0;
        else if (wdt_tmo_i)
            to_q <= 1'b1;
    end

    // Assemble the readable byte; upper bits stay zero
    always_comb begin
        status_o = DATA_W'({to_q, pdf_q, flags_q});
    end

    AST_HALT_SETS_PDF: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i && !wdt_clr_i |=> pdf_q); // R8
    AST_CLEAR_DROPS_PDF: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_i |=> !pdf_q); // R8
    AST_CLEAR_OR_HALT_DROPS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_i || halt_i |=> !to_q); // R9
    AST_EXPIRY_SETS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tmo_i && !wdt_clr_i && !halt_i |=> to_q); // R9
    AST_ALU_FLAGS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        alu_we_i |=> flags_q == $past(alu_flags_i)); // R10
    AST_SW_FLAGS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we_i && !alu_we_i |=> flags_q == $past(sw_flags_i)); // R7

endmodule

// File: rtl/regfile_dmem.sv
// Module: regfile_dmem (top)
// 64-location data memory: indirect port at address 0, pointer, accumulator,
// status register and a general-purpose RAM window. Unmapped locations read zero.
// Assumes: GP_BASE is a multiple of GP_DEPTH, GP_DEPTH is a power of two,
// and DATA_W > PTR_W > ADDR_W.
module regfile_dmem
    import dm_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 6,
    parameter int PTR_W     = 7,
    parameter int PTR_ADDR  = 1,
    parameter int ACC_ADDR  = 5,
    parameter int STAT_ADDR = 10,
    parameter int GP_BASE   = 32,
    parameter int GP_DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              alu_flag_we,
    input  logic              alu_c,
    input  logic              alu_ac,
    input  logic              alu_z,
    input  logic              alu_ov,
    input  logic              core_halt,
    input  logic              core_wdt_clear,
    input  logic              wdt_timeout,
    output logic [DATA_W-1:0] acc_value
);

    localparam int IDX_W   = $clog2(GP_DEPTH);
    localparam int PAD_W   = DATA_W - PTR_W;

    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] acc_q;
    logic [ADDR_W-1:0] rd_eff;
    logic [ADDR_W-1:0] wr_eff;
    loc_kind_e         rd_kind;
    loc_kind_e         wr_kind;
    logic [DATA_W-1:0] ram_rd;
    logic [DATA_W-1:0] stat_rd;
    logic              ram_we;
    logic              stat_we;
    alu_flags_t        alu_flags;
    alu_flags_t        sw_flags;

    dm_addr_route #(
        .ADDR_W   (ADDR_W),
        .PTR_ADDR (PTR_ADDR),
        .ACC_ADDR (ACC_ADDR),
        .STAT_ADDR(STAT_ADDR),
        .GP_BASE  (GP_BASE),
        .GP_DEPTH (GP_DEPTH)
    ) u_rd_route (
        .addr_i    (rd_addr),
        .ptr_low_i (ptr_q[ADDR_W-1:0]),
        .eff_addr_o(rd_eff),
        .kind_o    (rd_kind)
    );

    dm_addr_route #(
        .ADDR_W   (ADDR_W),
        .PTR_ADDR (PTR_ADDR),
        .ACC_ADDR (ACC_ADDR),
        .STAT_ADDR(STAT_ADDR),
        .GP_BASE  (GP_BASE),
        .GP_DEPTH (GP_DEPTH)
    ) u_wr_route (
        .addr_i    (wr_addr),
        .ptr_low_i (ptr_q[ADDR_W-1:0]),
        .eff_addr_o(wr_eff),
        .kind_o    (wr_kind)
    );

    // Per-target write enables from the resolved write address
    always_comb begin
        ram_we  = wr_en && (wr_kind == LOC_RAM);
        stat_we = wr_en && (wr_kind == LOC_STAT);
    end

    // Repack flag inputs into the shared struct
    always_comb begin
        alu_flags = '{ov: alu_ov, z: alu_z, ac: alu_ac, c: alu_c};
        sw_flags  = alu_flags_t'(wr_data[FLAG_W-1:0]);
    end

    // Pointer register keeps only its low PTR_W bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (wr_en && wr_kind == LOC_PTR)
            ptr_q <= wr_data[PTR_W-1:0];
    end

    // Accumulator register
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (wr_en && wr_kind == LOC_ACC)
            acc_q <= wr_data;
    end

    dm_gp_ram #(
        .DATA_W(DATA_W),
        .DEPTH (GP_DEPTH)
    ) u_gp_ram (
        .clk      (clk),
        .we_i     (ram_we),
        .wr_idx_i (wr_eff[IDX_W-1:0]),
        .wr_data_i(wr_data),
        .rd_idx_i (rd_eff[IDX_W-1:0]),
        .rd_data_o(ram_rd)
    );

    dm_status_reg #(
        .DATA_W(DATA_W)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_we_i    (stat_we),
        .sw_flags_i (sw_flags),
        .alu_we_i   (alu_flag_we),
        .alu_flags_i(alu_flags),
        .halt_i     (core_halt),
        .wdt_clr_i  (core_wdt_clear),
        .wdt_tmo_i  (wdt_timeout),
        .status_o   (stat_rd)
    );

    // Read multiplexer over the resolved location
    always_comb begin
        unique case (rd_kind)
            LOC_PTR:  rd_data = {{PAD_W{1'b1}}, ptr_q};
            LOC_ACC:  rd_data = acc_q;
            LOC_STAT: rd_data = stat_rd;
            LOC_RAM:  rd_data = ram_rd;
            default:  rd_data = '0;
        endcase
    end

    // Accumulator is visible to the core at all times
    always_comb begin
        acc_value = acc_q;
    end

    AST_PTR_READS_MSB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == ADDR_W'(PTR_ADDR) |-> rd_data[DATA_W-1]); // R3
    AST_PTR_LOADS_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == ADDR_W'(PTR_ADDR) |=> ptr_q == $past(wr_data[PTR_W-1:0])); // R3
    AST_SELF_REF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == '0 && ptr_q[ADDR_W-1:0] == '0 |-> rd_data == '0); // R2
    AST_ACC_HOLDS_UNLESS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_kind == LOC_ACC) |=> $stable(acc_q)); // R5

endmodule

// File: tb/regfile_dmem_bench.sv
module regfile_dmem_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       alu_flag_we = 1'b0;
    logic       alu_c = 1'b0, alu_ac = 1'b0, alu_z = 1'b0, alu_ov = 1'b0;
    logic       core_halt = 1'b0, core_wdt_clear = 1'b0, wdt_timeout = 1'b0;
    logic [7:0] acc_value;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    regfile_dmem u_regfile_dmem (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alu_flag_we(alu_flag_we), .alu_c(alu_c), .alu_ac(alu_ac),
        .alu_z(alu_z), .alu_ov(alu_ov), .core_halt(core_halt),
        .core_wdt_clear(core_wdt_clear), .wdt_timeout(wdt_timeout),
        .acc_value(acc_value)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // Called at a falling edge; leaves at the next falling edge
    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [5:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic events(input logic h, input logic c, input logic t);
        core_halt = h; core_wdt_clear = c; wdt_timeout = t;
        @(posedge clk); @(negedge clk);
        core_halt = 1'b0; core_wdt_clear = 1'b0; wdt_timeout = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        rd_check("R11 ptr", 6'h01, 8'h80);
        rd_check("R11 acc", 6'h05, 8'h00);
        rd_check("R11 status", 6'h0A, 8'h00);
        check("R11 acc_value", acc_value, 8'h00);
    endtask

    task automatic t_direct();
        wr(6'h05, 8'h5A);
        rd_check("R5 acc", 6'h05, 8'h5A);
        check("R5 acc_value", acc_value, 8'h5A);
        wr(6'h20, 8'h11);
        wr(6'h3F, 8'hEE);
        wr(6'h2A, 8'h3C);
        rd_check("R5 ram 20", 6'h20, 8'h11);
        rd_check("R5 ram 3F", 6'h3F, 8'hEE);
        rd_check("R5 ram 2A", 6'h2A, 8'h3C);
    endtask

    task automatic t_pointer();
        wr(6'h01, 8'hFF);
        rd_check("R3 ptr FF", 6'h01, 8'hFF);
        wr(6'h01, 8'h05);
        rd_check("R3 ptr 05", 6'h01, 8'h85);
    endtask

    task automatic t_indirect();
        wr(6'h01, 8'h21);
        wr(6'h00, 8'hC3);
        rd_check("R1 ind write", 6'h21, 8'hC3);
        rd_check("R1 ind read", 6'h00, 8'hC3);
        wr(6'h01, 8'h05);
        rd_check("R1 ind acc", 6'h00, 8'h5A);
        wr(6'h00, 8'h66);
        rd_check("R1 ind acc write", 6'h05, 8'h66);
    endtask

    task automatic t_wrap();
        wr(6'h25, 8'h77);
        wr(6'h01, 8'h65);
        rd_check("R4 wrap read", 6'h00, 8'h77);
        wr(6'h00, 8'h78);
        rd_check("R4 wrap write", 6'h25, 8'h78);
        rd_check("R4 ptr keeps bit6", 6'h01, 8'hE5);
    endtask

    task automatic t_self_ref();
        wr(6'h01, 8'h00);
        rd_check("R2 self read", 6'h00, 8'h00);
        wr(6'h00, 8'h99);
        rd_check("R2 ptr intact", 6'h01, 8'h80);
        rd_check("R2 acc intact", 6'h05, 8'h66);
        rd_check("R2 ram intact", 6'h20, 8'h11);
        rd_check("R2 status intact", 6'h0A, 8'h00);
        wr(6'h01, 8'h40);
        rd_check("R4 ptr 40 self read", 6'h00, 8'h00);
        wr(6'h00, 8'hAB);
        rd_check("R4 ptr 40 ptr intact", 6'h01, 8'hC0);
        rd_check("R4 ptr 40 acc intact", 6'h05, 8'h66);
    endtask

    task automatic t_unused();
        wr(6'h02, 8'hAA);
        wr(6'h06, 8'h55);
        wr(6'h0B, 8'hFF);
        wr(6'h1F, 8'h81);
        for (int a = 2; a < 32; a++) begin
            if (a != 5 && a != 10)
                rd_check("R6 unused reads zero", 6'(a), 8'h00);
        end
        rd_check("R6 acc undisturbed", 6'h05, 8'h66);
        rd_check("R6 status undisturbed", 6'h0A, 8'h00);
        rd_check("R6 ram undisturbed", 6'h3F, 8'hEE);
    endtask

    task automatic t_status_sw();
        wr(6'h0A, 8'hFF);
        rd_check("R7 sw write low nibble", 6'h0A, 8'h0F);
        wr(6'h0A, 8'h05);
        rd_check("R7 sw write 05", 6'h0A, 8'h05);
    endtask

    task automatic t_events();
        events(1'b1, 1'b0, 1'b0);
        rd_check("R8 halt sets PDF", 6'h0A, 8'h15);
        events(1'b0, 1'b0, 1'b1);
        rd_check("R9 expiry sets TO", 6'h0A, 8'h35);
        events(1'b0, 1'b1, 1'b0);
        rd_check("R8 R9 clear drops both", 6'h0A, 8'h05);
        events(1'b1, 1'b0, 1'b1);
        rd_check("R9 halt beats expiry", 6'h0A, 8'h15);
        events(1'b1, 1'b1, 1'b0);
        rd_check("R8 clear beats halt", 6'h0A, 8'h05);
        events(1'b0, 1'b1, 1'b1);
        rd_check("R9 clear beats expiry", 6'h0A, 8'h05);
    endtask

    task automatic t_alu_flags();
        alu_flag_we = 1'b1; alu_c = 1'b1; alu_ac = 1'b0; alu_z = 1'b1; alu_ov = 1'b1;
        wr(6'h0A, 8'h02);
        alu_flag_we = 1'b0;
        rd_check("R10 alu beats sw write", 6'h0A, 8'h0D);
        alu_flag_we = 1'b1; alu_c = 1'b0; alu_ac = 1'b1; alu_z = 1'b0; alu_ov = 1'b0;
        @(posedge clk); @(negedge clk);
        alu_flag_we = 1'b0;
        rd_check("R10 alu alone", 6'h0A, 8'h02);
    endtask

    task automatic t_reset_again();
        events(1'b1, 1'b0, 1'b0);
        events(1'b0, 1'b0, 1'b1);
        wr(6'h01, 8'h33);
        do_reset();
        t_reset_state();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_reset_state();
        t_direct();
        t_pointer();
        t_indirect();
        t_wrap();
        t_self_ref();
        t_unused();
        t_status_sw();
        t_events();
        t_alu_flags();
        t_reset_again();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule